// File: doc/BRIEF.md
# Millisecond Interval Timer

This block is a periodic interrupt source for a processor subsystem. Software programs a reload value over a 32-bit register port. The block turns that value into a tick rate of 1000/(reload+1) events per second, using integer division. It then counts out the matching period in microseconds and raises a level interrupt each time a period ends. Counting continues without a gap into the next period.

Software restarts the timer by writing the reload register. It acknowledges an interrupt by reading the count register, which always returns zero. An internal prescaler turns the system clock into a one-microsecond strobe. The period is held as a microsecond count, so the rounding of both integer divisions shows up exactly in the interrupt spacing. A reload value of 1000 or more gives a rate of zero. The timer then stays stopped and never interrupts.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset the interrupt output is low and the reload register reads back 0, which selects a 1000 us period.
- R2: A write at offset 0x228 stores all 32 bits of the reload value, and a read at 0x228 returns that value on rdata in the same cycle.
- R3: A running period lasts P = 1000000 / (1000 / (reload + 1)) microseconds, with both divisions truncating. For example, reload 0 gives 1000 us, reload 2 gives 3003 us and reload 6 gives 7042 us.
- R4: One microsecond is CYCLES_PER_US clock cycles. After reset or a restart, the interrupt rises exactly P * CYCLES_PER_US cycles later.
- R5: A write at 0x228 drives the interrupt low on the next cycle and restarts the period from that write, discarding any partly counted time.
- R6: When a period ends, the interrupt is set and the next period begins in the same cycle, so expiries repeat every P microseconds.
- R7: A read at 0x230 returns 0 on rdata and clears the interrupt on the next cycle.
- R8: If a period ends in the same cycle as a read at 0x230, the interrupt is set. The new expiry wins over the acknowledge.
- R9: A reload value of 1000 or more, up to 0xFFFFFFFF, stops the timer, and the interrupt never rises.
- R10: Writes to any offset other than 0x228 change neither the interrupt, the running period nor the reload value. Reads at offsets other than 0x228 return 0.
- R11: The interrupt is a level. Once set, it stays high across later expiries until software acknowledges it or restarts the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with CYCLES_PER_US = 2 and keeps the default offsets. This makes periods of 1000 to 7042 us last 2000 to 14084 clock cycles. The exact rise cycle can then be checked for reloads 0, 1, 2 and 6, where 6 is the case in which the rate division rounds down. The stopped range is checked with 1000 and 0xFFFFFFFF. A two-cycle microsecond also exercises the prescaler wrap and its restart on a reload write. A one-second period (reload 999) lies outside the bench's cycle budget.

// File: rtl/itm_pkg.sv
package itm_pkg;

    // Width of a period expressed in microseconds (up to 1_000_000).
    localparam int unsigned PER_W    = 20;
    localparam int unsigned RATE_HZ  = 1000;
    localparam int unsigned US_PER_S = 1_000_000;

    // Kind of register access seen this cycle, in priority order.
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_RESTART = 2'd1,
        ACC_ACK     = 2'd2
    } itm_acc_e;

    // Programmed configuration: raw reload value and derived period.
    typedef struct packed {
        logic [31:0]      reload;
        logic [PER_W-1:0] period_us;
    } itm_cfg_t;

    // Period in microseconds for a reload value; zero means stopped.
    function automatic logic [PER_W-1:0] itm_period_us(input logic [31:0] reload);
        logic [10:0] divisor;
        logic [9:0]  rate;
        if (reload >= 32'(RATE_HZ)) begin
            return '0;
        end
        divisor = 11'(reload[9:0]) + 11'd1;
        rate    = 10'(11'(RATE_HZ) / divisor);
        return PER_W'(US_PER_S / 32'(rate));
    endfunction

    function automatic itm_acc_e itm_decode(input logic wr, input logic rd,
                                            input logic hit_reload, input logic hit_count);
        if (wr && hit_reload) begin
            return ACC_RESTART;
        end
        if (rd && hit_count) begin
            return ACC_ACK;
        end
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/itm_prescaler.sv
module itm_prescaler #(
    parameter int unsigned CYCLES_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic us_tick
);
    localparam int unsigned PW  = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
    localparam logic [PW-1:0] LIM = PW'(CYCLES_PER_US - 1);

    logic [PW-1:0] pre_cnt;

    assign us_tick = (pre_cnt == LIM);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
        end else if (us_tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/itm_period_ctr.sv
module itm_period_ctr
    import itm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             us_tick,
    input  logic [PER_W-1:0] period_us,
    output logic             expire
);
    logic [PER_W-1:0] us_cnt;
    logic             running;

    assign running = (period_us != '0);
    assign expire  = us_tick && running && (us_cnt == period_us - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            us_cnt <= '0;
        end else if (us_tick && running) begin
            us_cnt <= expire ? '0 : us_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
    import itm_pkg::*;
#(
    parameter int unsigned     CYCLES_PER_US = 50,
    parameter int unsigned     ADDR_W        = 14,
    parameter logic [ADDR_W-1:0] RELOAD_OFS  = ADDR_W'('h228),
    parameter logic [ADDR_W-1:0] COUNT_OFS   = ADDR_W'('h230)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    itm_cfg_t         cfg_q;
    itm_acc_e         acc;
    logic             restart;
    logic             us_tick;
    logic             expire;
    logic [PER_W-1:0] period_q;

    assign acc      = itm_decode(wr_en, rd_en, addr == RELOAD_OFS, addr == COUNT_OFS);
    assign restart  = (acc == ACC_RESTART);
    assign period_q = cfg_q.period_us;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.reload    <= '0;
            cfg_q.period_us <= itm_period_us(32'd0);
        end else if (restart) begin
            cfg_q.reload    <= wdata;
            cfg_q.period_us <= itm_period_us(wdata);
        end
    end

    itm_prescaler #(.CYCLES_PER_US(CYCLES_PER_US)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .us_tick (us_tick)
    );

    itm_period_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .us_tick   (us_tick),
        .period_us (period_q),
        .expire    (expire)
    );

    // Restart clears, a fresh expiry beats an acknowledge.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            irq <= 1'b0;
        end else if (expire) begin
            irq <= 1'b1;
        end else if (acc == ACC_ACK) begin
            irq <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && (addr == RELOAD_OFS)) begin
            rdata = cfg_q.reload;
        end
    end
endmodule

// File: rtl/itm_checker.sv
module itm_checker
    import itm_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 14,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = ADDR_W'('h228),
    parameter logic [ADDR_W-1:0] COUNT_OFS  = ADDR_W'('h230)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              expire,
    input logic [PER_W-1:0]  period_q
);
    logic wr_rl;
    logic rd_ct;
    assign wr_rl = wr_en && (addr == RELOAD_OFS);
    assign rd_ct = rd_en && (addr == COUNT_OFS);

    assert_restart_drops_irq_R5: assert property (@(posedge clk) disable iff (rst)
        wr_rl |=> !irq);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_ct && !expire) |=> !irq);

    assert_count_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rd_ct |-> (rdata == 32'd0));

    assert_expiry_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (expire && !wr_rl) |=> irq);

    assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(expire));

    assert_stopped_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (period_q == '0) |-> !expire);

    assert_level_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_ct && !wr_rl) |=> irq);
endmodule

bind ms_interval_timer itm_checker #(
    .ADDR_W     (ADDR_W),
    .RELOAD_OFS (RELOAD_OFS),
    .COUNT_OFS  (COUNT_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .expire   (expire),
    .period_q (period_q)
);

// File: tb/ms_interval_timer_tb.sv
`timescale 1ns/1ps
module ms_interval_timer_tb;
    localparam int unsigned CYC    = 2;
    localparam int unsigned AW     = 14;
    localparam logic [AW-1:0] A_RL = 14'h228;
    localparam logic [AW-1:0] A_CT = 14'h230;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    logic run_cmp = 1'b0;

    always #10 clk = ~clk;

    ms_interval_timer #(.CYCLES_PER_US(CYC), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference: cycles left until the next expiry.
    function automatic longint per_us(input logic [31:0] r);
        longint rate;
        if (r >= 32'd1000) return 0;
        rate = 1000 / (longint'(r) + 1);
        return 1000000 / rate;
    endfunction

    logic   m_irq = 1'b0;
    longint m_left = 0;
    longint m_per  = 1000;

    always @(posedge clk) begin
        if (rst) begin
            m_irq  = 1'b0;
            m_per  = 1000;
            m_left = m_per * CYC;
        end else if (wr_en && addr == A_RL) begin
            m_per  = per_us(wdata);
            m_left = m_per * CYC;
            m_irq  = 1'b0;
        end else begin
            logic ex;
            ex = 1'b0;
            if (m_left != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    ex = 1'b1;
                    m_left = m_per * CYC;
                end
            end
            if (ex) m_irq = 1'b1;
            else if (rd_en && addr == A_CT) m_irq = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            n_checks++;
            if (irq !== m_irq) begin
                n_fail++;
                $display("FAIL %s model irq actual=%0b expected=%0b at %0t", cur_req, irq, m_irq, $time);
            end
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    // Checks the rise edge count after a write that just completed.
    task automatic expect_rise(input longint cycles, input string req);
        idle(int'(cycles) - 1);
        check(irq == 1'b0, req, irq, 0);
        idle(1);
        check(irq == 1'b1, req, irq, 1);
    endtask

    logic done = 1'b0;

    initial begin
        logic [31:0] rd;
        idle(3);
        rst = 1'b0;
        run_cmp = 1'b1;
        // R1: reset state
        check(irq == 1'b0, "R1", irq, 0);
        do_read(A_RL, rd);
        check(rd == 32'd0, "R1", rd, 0);
        // R3/R4: first expiry after reset at 1000 us * CYC
        cur_req = "R4";
        idle(1997);
        check(irq == 1'b0, "R4", irq, 0);
        idle(1);
        check(irq == 1'b1, "R3", irq, 1);

        // R7: acknowledge by reading count
        cur_req = "R7";
        do_read(A_CT, rd);
        check(rd == 32'd0, "R7", rd, 0);
        check(irq == 1'b0, "R7", irq, 1);

        // R2/R3/R5: reload 2 -> 3003 us
        cur_req = "R3";
        do_write(A_RL, 32'd2);
        do_read(A_RL, rd);
        check(rd == 32'd2, "R2", rd, 2);
        expect_rise(3003 * CYC - 2, "R3");

        // R11/R6: level holds across later expiries, periodic model tracked
        cur_req = "R11";
        idle(3003 * CYC * 2);
        check(irq == 1'b1, "R11", irq, 1);
        cur_req = "R6";
        do_read(A_CT, rd);
        idle(3003 * CYC);
        check(irq == 1'b1, "R6", irq, 1);

        // R5: restart while pending drops irq, reload 1 -> 2000 us
        cur_req = "R5";
        do_write(A_RL, 32'd1);
        check(irq == 1'b0, "R5", irq, 0);
        expect_rise(2000 * CYC, "R5");

        // R10: writes elsewhere are ignored, other reads give zero
        cur_req = "R10";
        do_write(A_CT, 32'd5);
        check(irq == 1'b1, "R10", irq, 1);
        do_write(14'h100, 32'd0);
        check(irq == 1'b1, "R10", irq, 1);
        do_read(A_RL, rd);
        check(rd == 32'd1, "R10", rd, 1);
        do_read(14'h100, rd);
        check(rd == 32'd0, "R10", rd, 0);

        // R8: acknowledge in the expiry cycle loses to the expiry
        cur_req = "R8";
        do_read(A_CT, rd);
        check(irq == 1'b0, "R7", irq, 0);
        while (m_left != 1) @(negedge clk);
        rd_en = 1'b1; addr = A_CT;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        check(irq == 1'b1, "R8", irq, 1);

        // R3: rounding case reload 6 -> 7042 us
        cur_req = "R3";
        do_write(A_RL, 32'd6);
        expect_rise(7042 * CYC, "R3");

        // R9: stopped range
        cur_req = "R9";
        do_write(A_RL, 32'd1000);
        idle(20000);
        check(irq == 1'b0, "R9", irq, 0);
        do_write(A_RL, 32'hFFFF_FFFF);
        idle(6000);
        check(irq == 1'b0, "R9", irq, 0);

        run_cmp = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule